// File: doc/BRIEF.md
# PCI Cache Command Selector

This block sits beside a bus-master engine and picks the PCI bus command used for each master transfer. For every request it looks at the programmed cache line size, a global cache enable, one enable per cache command, a 3-bit burst length code, and the transfer itself: its class, direction, start byte address and length in Dwords. From these it returns a 4-bit command code, plus a flag that tells the engine to align a write to the next line boundary first.

A cache command is chosen only when all four gates hold together. The line size must be a legal power of two. The burst must be at least one line long. The transfer class must be eligible. The enable for that command must be set. If any gate fails, the block issues a plain Memory Read or Memory Write and does not request alignment. The decision is captured on the clock edge that sees the request strobe. It is presented on the next cycle together with a one-cycle valid pulse, and it holds until the next request.

Top module: `pci_cmd_select`

## Requirements
- R1: `valid_o` is high for exactly the one cycle after a cycle in which `req_i` was high, and low otherwise. `cmd_o` and `align_o` are updated in that same cycle and hold until the next request.
- R2: When `cache_en_i` is low, the result is Memory Read (read) or Memory Write (write), with `align_o` low.
- R3: `line_size_i` is eligible only for the values 2, 4, 8, 16, 32, 64 or 128 Dwords. Any other value (0, 1, 3, 96, 255, ...) gives a plain read or write with `align_o` low.
- R4: `burst_code_i` selects 2<<code Dwords for codes 0 to 6. Code 7 is reserved and counts as a failed burst test. A burst shorter than the line size also gives a plain read or write.
- R5: `xfer_class_i` encoding is 0 = general master transfer, 1 = non-prefetch instruction fetch, 2 = load/store move, 3 = flush. Only class 0 is eligible; classes 1 to 3 always give a plain read or write with `align_o` low.
- R6: An eligible read spans more than one line when (start Dword offset within its line) + length > line size. Such a read gives Memory Read Multiple if `en_mrm_i` is set, otherwise Memory Read Line if `en_mrl_i` is set, otherwise Memory Read.
- R7: An eligible read that stays within one line gives Memory Read Line if `en_mrl_i` is set, otherwise Memory Read. `en_mrm_i` has no effect on it.
- R8: An eligible write gives Memory Write and Invalidate only when three things hold: it starts on a line boundary, its length is at least one line, and both `en_mwi_a_i` and `en_mwi_b_i` are set. An aligned write that misses any of these gives Memory Write with `align_o` low.
- R9: An eligible write whose start is not on a line boundary gives Memory Write with `align_o` high. `align_o` is never high with any other command.
- R10: Command codes on `cmd_o` are Memory Read 4'b0110, Memory Write 4'b0111, Memory Read Multiple 4'b1100, Memory Read Line 4'b1110, Memory Write and Invalidate 4'b1111. `write_i` = 1 always yields a write code and `write_i` = 0 a read code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe; transfer fields are sampled with it |
| line_size_i | input | LS_W (8) | Cache line size in Dwords |
| cache_en_i | input | 1 | Global cache command enable |
| en_mrl_i | input | 1 | Memory Read Line enable |
| en_mrm_i | input | 1 | Memory Read Multiple enable |
| en_mwi_a_i | input | 1 | First Memory Write and Invalidate enable |
| en_mwi_b_i | input | 1 | Second Memory Write and Invalidate enable |
| burst_code_i | input | 3 | Burst length code |
| xfer_class_i | input | 2 | Transfer class (0 general, 1 fetch, 2 load/store, 3 flush) |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (32) | Start byte address |
| len_dw_i | input | LEN_W (16) | Transfer length in Dwords |
| valid_o | output | 1 | One-cycle decision pulse |
| cmd_o | output | 4 | PCI command code |
| align_o | output | 1 | Write must be aligned to a line boundary first |

## Verification
The checker tests several rules on every cycle, relating each decision to the inputs captured in the previous cycle:
- the timing of the valid pulse;
- the fallback to plain commands when the global enable is off, when the class is a bypass class, or when the burst code is reserved;
- that the direction always matches the command family;
- that alignment only goes with Memory Write;
- that Memory Write and Invalidate never appears without both of its enables.

Other behaviour can only be shown by the bench's scenarios. This covers the exact choice among Memory Read, Memory Read Line and Memory Read Multiple under line spanning, the line boundary and full-line tests for writes, the full sweep of line-size values, and the burst-versus-line comparison. The bench compares each of these against its own model.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [3:0] {
    CMD_MR  = 4'b0110,
    CMD_MW  = 4'b0111,
    CMD_MRM = 4'b1100,
    CMD_MRL = 4'b1110,
    CMD_MWI = 4'b1111
  } pci_cmd_e;

  typedef enum logic [1:0] {
    XC_GENERAL  = 2'd0,
    XC_FETCH_NP = 2'd1,
    XC_LDST     = 2'd2,
    XC_FLUSH    = 2'd3
  } xfer_class_e;

  typedef struct packed {
    pci_cmd_e cmd;
    logic     align;
  } decision_t;

  localparam int unsigned MAX_LINE_LOG2 = 7;
endpackage

// File: rtl/pcs_line_check.sv
module pcs_line_check #(
  parameter int unsigned LS_W = 8
) (
  input  logic [LS_W-1:0]                    line_size,
  output logic                               line_ok,
  output logic [pcs_pkg::MAX_LINE_LOG2-1:0]  line_mask
);
  localparam int unsigned NLOG = pcs_pkg::MAX_LINE_LOG2;

  logic [NLOG:1] hit;

  genvar k;
  generate
    for (k = 1; k <= NLOG; k++) begin : g_size
      assign hit[k] = (line_size == LS_W'(1 << k));
    end
  endgenerate

  always_comb begin
    line_ok   = |hit;
    line_mask = '0;
    for (int j = 1; j <= NLOG; j++) begin
      if (hit[j]) line_mask = NLOG'((1 << j) - 1);
    end
  end
endmodule

// File: rtl/pcs_burst_check.sv
module pcs_burst_check #(
  parameter int unsigned LS_W = 8
) (
  input  logic [2:0]      burst_code,
  input  logic [LS_W-1:0] line_size,
  output logic            burst_ok
);
  localparam int unsigned BW = (LS_W > 8) ? LS_W : 8;

  logic [BW-1:0] burst_dw;
  logic          reserved;

  always_comb begin
    reserved = (burst_code == 3'b111);
    burst_dw = reserved ? '0 : BW'(2) << burst_code;
    burst_ok = !reserved && (burst_dw >= BW'(line_size));
  end
endmodule

// File: rtl/pcs_geom.sv
module pcs_geom #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned LS_W   = 8
) (
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [LEN_W-1:0]                   len_dw,
  input  logic [LS_W-1:0]                    line_size,
  input  logic [pcs_pkg::MAX_LINE_LOG2-1:0]  line_mask,
  output logic                               aligned,
  output logic                               spans,
  output logic                               covers
);
  localparam int unsigned NLOG = pcs_pkg::MAX_LINE_LOG2;
  localparam int unsigned SW   = ((LEN_W > LS_W) ? LEN_W : LS_W) + 1;

  logic [NLOG-1:0] offset;
  logic [SW-1:0]   reach;

  always_comb begin
    offset  = addr[NLOG+1:2] & line_mask;
    reach   = SW'(offset) + SW'(len_dw);
    aligned = (offset == '0);
    spans   = reach > SW'(line_size);
    covers  = SW'(len_dw) >= SW'(line_size);
  end
endmodule

// File: rtl/pcs_cmd_pick.sv
module pcs_cmd_pick
  import pcs_pkg::*;
(
  input  logic      eligible,
  input  logic      write,
  input  logic      aligned,
  input  logic      spans,
  input  logic      covers,
  input  logic      en_mrl,
  input  logic      en_mrm,
  input  logic      en_mwi,
  output decision_t dec
);
  always_comb begin
    dec.align = 1'b0;
    if (!eligible) begin
      dec.cmd = write ? CMD_MW : CMD_MR;
    end else if (write) begin
      if (!aligned) begin
        dec.cmd   = CMD_MW;
        dec.align = 1'b1;
      end else if (covers && en_mwi) begin
        dec.cmd = CMD_MWI;
      end else begin
        dec.cmd = CMD_MW;
      end
    end else if (spans && en_mrm) begin
      dec.cmd = CMD_MRM;
    end else if (en_mrl) begin
      dec.cmd = CMD_MRL;
    end else begin
      dec.cmd = CMD_MR;
    end
  end
endmodule

// File: rtl/pci_cmd_select.sv
module pci_cmd_select
  import pcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned LS_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [LS_W-1:0]   line_size_i,
  input  logic              cache_en_i,
  input  logic              en_mrl_i,
  input  logic              en_mrm_i,
  input  logic              en_mwi_a_i,
  input  logic              en_mwi_b_i,
  input  logic [2:0]        burst_code_i,
  input  logic [1:0]        xfer_class_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_dw_i,
  output logic              valid_o,
  output logic [3:0]        cmd_o,
  output logic              align_o
);
  localparam int unsigned NLOG = MAX_LINE_LOG2;

  logic            line_ok;
  logic [NLOG-1:0] line_mask;
  logic            burst_ok;
  logic            class_ok;
  logic            eligible;
  logic            aligned, spans, covers;
  decision_t       dec_d, dec_q;
  logic            valid_d, valid_q;

  pcs_line_check #(.LS_W(LS_W)) u_line (
    .line_size (line_size_i),
    .line_ok   (line_ok),
    .line_mask (line_mask)
  );

  pcs_burst_check #(.LS_W(LS_W)) u_burst (
    .burst_code (burst_code_i),
    .line_size  (line_size_i),
    .burst_ok   (burst_ok)
  );

  pcs_geom #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LS_W(LS_W)) u_geom (
    .addr      (addr_i),
    .len_dw    (len_dw_i),
    .line_size (line_size_i),
    .line_mask (line_mask),
    .aligned   (aligned),
    .spans     (spans),
    .covers    (covers)
  );

  always_comb begin
    class_ok = (xfer_class_e'(xfer_class_i) == XC_GENERAL);
    eligible = cache_en_i && line_ok && burst_ok && class_ok;
  end

  pcs_cmd_pick u_pick (
    .eligible (eligible),
    .write    (write_i),
    .aligned  (aligned),
    .spans    (spans),
    .covers   (covers),
    .en_mrl   (en_mrl_i),
    .en_mrm   (en_mrm_i),
    .en_mwi   (en_mwi_a_i && en_mwi_b_i),
    .dec      (dec_d)
  );

  // next-state
  always_comb begin
    valid_d = req_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q.cmd   <= CMD_MR;
      dec_q.align <= 1'b0;
    end else if (req_i) begin
      dec_q <= dec_d;
    end
  end

  assign valid_o = valid_q;
  assign cmd_o   = dec_q.cmd;
  assign align_o = dec_q.align;
endmodule

// File: rtl/pcs_chk.sv
module pcs_chk
  import pcs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_i,
  input logic       cache_en_i,
  input logic       en_mwi_a_i,
  input logic       en_mwi_b_i,
  input logic [2:0] burst_code_i,
  input logic [1:0] xfer_class_i,
  input logic       write_i,
  input logic       valid_o,
  input logic [3:0] cmd_o,
  input logic       align_o
);
  logic plain;
  assign plain = (cmd_o == CMD_MR) || (cmd_o == CMD_MW);

  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o == $past(req_i));

  // R2
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !$past(cache_en_i)) |-> (plain && !align_o));

  // R4
  reserved_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(burst_code_i) == 3'b111) |-> (plain && !align_o));

  // R5
  bypass_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(xfer_class_i) != 2'd0) |-> (plain && !align_o));

  // R8
  mwi_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cmd_o == CMD_MWI) |-> ($past(en_mwi_a_i) && $past(en_mwi_b_i)));

  // R9
  align_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && align_o) |-> (cmd_o == CMD_MW));

  // R10
  write_family_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(write_i)) |-> (cmd_o == CMD_MW || cmd_o == CMD_MWI));

  // R10
  read_family_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !$past(write_i)) |->
      (cmd_o == CMD_MR || cmd_o == CMD_MRL || cmd_o == CMD_MRM));
endmodule

bind pci_cmd_select pcs_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .cache_en_i   (cache_en_i),
  .en_mwi_a_i   (en_mwi_a_i),
  .en_mwi_b_i   (en_mwi_b_i),
  .burst_code_i (burst_code_i),
  .xfer_class_i (xfer_class_i),
  .write_i      (write_i),
  .valid_o      (valid_o),
  .cmd_o        (cmd_o),
  .align_o      (align_o)
);

// File: tb/tb_pci_cmd_select.sv
module tb_pci_cmd_select;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] MR  = 4'b0110;
  localparam logic [3:0] MW  = 4'b0111;
  localparam logic [3:0] MRM = 4'b1100;
  localparam logic [3:0] MRL = 4'b1110;
  localparam logic [3:0] MWI = 4'b1111;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [7:0]  line;
  logic        cen, mrl, mrm, mwa, mwb;
  logic [2:0]  bc;
  logic [1:0]  cls;
  logic        wr;
  logic [31:0] addr;
  logic [15:0] len;
  logic        valid;
  logic [3:0]  cmd;
  logic        align;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_cmd_select dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .line_size_i(line),
    .cache_en_i(cen), .en_mrl_i(mrl), .en_mrm_i(mrm),
    .en_mwi_a_i(mwa), .en_mwi_b_i(mwb), .burst_code_i(bc),
    .xfer_class_i(cls), .write_i(wr), .addr_i(addr), .len_dw_i(len),
    .valid_o(valid), .cmd_o(cmd), .align_o(align)
  );

  function automatic void model(output logic [3:0] c, output logic a);
    int l, bd, off;
    bit lok, elig;
    l   = int'(line);
    lok = (l == 2 || l == 4 || l == 8 || l == 16 || l == 32 || l == 64 || l == 128);
    bd  = (bc == 3'd7) ? 0 : (2 ** (int'(bc) + 1));
    elig = cen && lok && (bc != 3'd7) && (bd >= l) && (cls == 2'd0);
    a = 1'b0;
    if (!elig) begin
      c = wr ? MW : MR;
      return;
    end
    off = (int'(addr) / 4) % l;
    if (wr) begin
      if (off != 0) begin c = MW; a = 1'b1; end
      else if (int'(len) >= l && mwa && mwb) c = MWI;
      else c = MW;
    end else if (off + int'(len) > l) begin
      c = mrm ? MRM : (mrl ? MRL : MR);
    end else begin
      c = mrl ? MRL : MR;
    end
  endfunction

  task automatic check(string tag, logic [3:0] ec, logic ea, logic ev);
    total++;
    if (cmd !== ec || align !== ea || valid !== ev) begin
      bad++;
      $display("FAIL %s: cmd=%b align=%b valid=%b expected cmd=%b align=%b valid=%b",
               tag, cmd, align, valid, ec, ea, ev);
    end
  endtask

  // inputs are already set; pulse req and check the registered result
  task automatic fire(string tag, logic [3:0] ec, logic ea);
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(tag, ec, ea, 1'b1);
  endtask

  task automatic fire_model(string tag);
    logic [3:0] ec;
    logic ea;
    model(ec, ea);
    fire(tag, ec, ea);
  endtask

  task automatic set_good();
    line = 8'd8; cen = 1; mrl = 1; mrm = 1; mwa = 1; mwb = 1;
    bc = 3'd3; cls = 2'd0; wr = 0; addr = 32'h0; len = 16'd1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = 1'b0;
    set_good();
    repeat (3) @(negedge clk);
    check("R1 reset state", MR, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", MR, 1'b0, 1'b0);
  endtask

  task automatic t_pulse();
    set_good(); wr = 1; addr = 32'h4;
    fire("R1 pulse", MW, 1'b1);
    @(negedge clk);
    check("R1 pulse ends, result held", MW, 1'b1, 1'b0);
  endtask

  task automatic t_global_off();
    set_good(); cen = 0;
    fire("R2 read off", MR, 1'b0);
    wr = 1; addr = 32'h4;
    fire("R2 unaligned write off", MW, 1'b0);
    addr = 32'h0; len = 16'd8;
    fire("R2 full write off", MW, 1'b0);
  endtask

  task automatic t_line_sweep();
    for (int v = 0; v < 256; v++) begin
      set_good(); line = 8'(v); bc = 3'd6;
      fire_model("R3 line sweep read");
      wr = 1; addr = 32'h4;
      fire_model("R3 line sweep write");
    end
    set_good(); line = 8'd1; bc = 3'd6;
    fire("R3 line 1 invalid", MR, 1'b0);
    line = 8'd128;
    fire("R3 line 128 valid", MRL, 1'b0);
  endtask

  task automatic t_burst();
    set_good(); line = 8'd16;
    bc = 3'd2;
    fire("R4 burst 8 < line 16", MR, 1'b0);
    bc = 3'd3;
    fire("R4 burst 16 = line 16", MRL, 1'b0);
    bc = 3'd7;
    fire("R4 reserved burst", MR, 1'b0);
    line = 8'd2; bc = 3'd0;
    fire("R4 burst 2 = line 2", MRL, 1'b0);
  endtask

  task automatic t_class();
    for (int k = 1; k < 4; k++) begin
      set_good(); cls = 2'(k); addr = 32'h1C; len = 16'd4;
      fire("R5 bypass class read", MR, 1'b0);
      wr = 1;
      fire("R5 bypass class write", MW, 1'b0);
    end
  endtask

  task automatic t_read_span();
    set_good(); addr = 32'h1C; len = 16'd2;
    fire("R6 span with MRM", MRM, 1'b0);
    mrm = 0;
    fire("R6 span fallback MRL", MRL, 1'b0);
    mrl = 0;
    fire("R6 span fallback MR", MR, 1'b0);
    set_good(); addr = 32'h0; len = 16'd8;
    fire("R7 exactly one line", MRL, 1'b0);
    mrl = 0;
    fire("R7 within line no MRL", MR, 1'b0);
    set_good(); addr = 32'h1C; len = 16'd1;
    fire("R7 last dword within line", MRL, 1'b0);
  endtask

  task automatic t_write();
    set_good(); line = 8'd4; bc = 3'd1; wr = 1; addr = 32'h10; len = 16'd4;
    fire("R8 aligned full line", MWI, 1'b0);
    mwb = 0;
    fire("R8 one enable only", MW, 1'b0);
    mwb = 1; mwa = 0;
    fire("R8 other enable only", MW, 1'b0);
    mwa = 1; len = 16'd3;
    fire("R8 short write", MW, 1'b0);
    len = 16'd4; addr = 32'h14;
    fire("R9 unaligned write", MW, 1'b1);
    addr = 32'h13;
    fire("R9 byte offset only is aligned", MWI, 1'b0);
  endtask

  task automatic t_matrix();
    int lines[10] = '{2, 4, 8, 16, 32, 64, 128, 0, 3, 96};
    int n = 0;
    for (int li = 0; li < 10; li++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 4; c++)
          for (int e = 0; e < 16; e++)
            for (int w = 0; w < 2; w++) begin
              line = 8'(lines[li]); cen = 1'b1; bc = 3'(b); cls = 2'(c);
              {mrl, mrm, mwa, mwb} = 4'(e); wr = 1'(w);
              addr = 32'((n * 52) % 1024);
              len  = 16'((n * 7) % 300);
              n++;
              fire_model("R10 matrix vs model");
            end
  endtask

  initial begin
    t_reset();
    t_pulse();
    t_global_off();
    t_line_sweep();
    t_burst();
    t_class();
    t_read_span();
    t_write();
    t_matrix();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule